// File: doc/BRIEF.md
# Filtered Command History Recorder

This block keeps a record of 8-bit broadcast commands as they arrive. It stores each one in a 512-entry history memory, in arrival order. A discard filter can sit in front of the memory. It holds 16 entries, and any command that matches an enabled entry is thrown away instead of stored. Each entry holds a command value, a per-bit ignore mask and an enable bit.

Control and observation use simple register-style pins:
- a history enable and a filter enable;
- indexed writes and reads of the filter entries;
- a pulse that clears the whole filter list;
- a pulse that empties the history;
- a live entry count and a full flag;
- an indexed readout port with one cycle of latency.

Top module: `cmd_hist_rec`

## Requirements
- R1: With `hist_en` high, a command presented with `cmd_valid` that is not discarded is written at index `count`, and `count` rises by one on that clock edge. Entries keep their arrival order from index 0.
- R2: While `hist_en` is low, no command is stored and `count` does not change.
- R3: A filter entry is 17 bits wide. Bits 7:0 hold the value to compare, bits 15:8 hold a mask in which a 1 means that bit is ignored, and bit 16 enables the entry. `flt_wr` writes `flt_wdata` into entry `flt_idx`. `flt_rdata` shows entry `flt_idx` in the same cycle.
- R4: While `filt_en` is high, a command that matches at least one enabled entry on every unmasked bit is discarded.
- R5: A disabled entry never discards a command. While `filt_en` is low, every command is stored whatever the filter holds.
- R6: A `hist_clr` pulse sets `count` to 0 and drops `full` on the next edge. A command presented in the same cycle as `hist_clr` is discarded.
- R7: A `flt_clr` pulse sets all 16 filter entries to zero. It takes priority over a `flt_wr` in the same cycle.
- R8: `count` never exceeds 512. At 512, `full` is high and further commands are dropped until the next `hist_clr`.
- R9: On each edge, `rd_data` loads the entry at `rd_idx` if `rd_idx` is below `count`, and loads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hist_en | input | 1 | Enables history capture |
| filt_en | input | 1 | Enables the discard filter |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_data | input | 8 | Command value |
| hist_clr | input | 1 | Empties the history |
| flt_clr | input | 1 | Zeroes all filter entries |
| flt_wr | input | 1 | Writes one filter entry |
| flt_idx | input | 4 | Filter entry index for write and read |
| flt_wdata | input | 17 | Filter entry write data |
| flt_rdata | output | 17 | Filter entry at `flt_idx` |
| count | output | 10 | Number of stored entries |
| full | output | 1 | History holds 512 entries |
| rd_idx | input | 9 | Readout index |
| rd_data | output | 8 | Registered readout data |

## Verification
Two events can land in the same cycle: a history clear and an arriving command. The bench provokes this by raising `hist_clr` and `cmd_valid` on the same edge, once from a full history and once from an empty one. It then expects `count` at zero, `full` low, and index 0 reading back as zero, which shows the command was not stored. A filter clear issued together with a filter write is judged the same way, through `flt_rdata`.

// File: rtl/cmd_hist_rec.sv
module cmd_hist_rec #(
  parameter int CMD_W = 8,
  parameter int DEPTH = 512,
  parameter int NFILT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hist_en,
  input  logic                       filt_en,
  input  logic                       cmd_valid,
  input  logic [CMD_W-1:0]           cmd_data,
  input  logic                       hist_clr,
  input  logic                       flt_clr,
  input  logic                       flt_wr,
  input  logic [$clog2(NFILT)-1:0]   flt_idx,
  input  logic [2*CMD_W:0]           flt_wdata,
  output logic [2*CMD_W:0]           flt_rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [CMD_W-1:0]           rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 2 * CMD_W + 1;

  logic [EW-1:0]    flt_q [NFILT];
  logic [CMD_W-1:0] mem   [DEPTH];
  logic [NFILT-1:0] hit_v;
  logic             store;

  for (genvar g = 0; g < NFILT; g++) begin : g_match
    assign hit_v[g] = flt_q[g][EW-1] &&
      (((cmd_data ^ flt_q[g][CMD_W-1:0]) & ~flt_q[g][2*CMD_W-1:CMD_W]) == '0);
  end

  assign full      = (count == CW'(DEPTH));
  assign store     = cmd_valid && hist_en && !hist_clr && !full && !(filt_en && |hit_v);
  assign flt_rdata = flt_q[flt_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || flt_clr) begin
      for (int i = 0; i < NFILT; i++) flt_q[i] <= '0;
    end else if (flt_wr) begin
      flt_q[flt_idx] <= flt_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hist_clr) count <= '0;
    else if (store)         count <= count + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (store) mem[count[AW-1:0]] <= cmd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   rd_data <= '0;
    else if (CW'(rd_idx) < count) rd_data <= mem[rd_idx];
    else                          rd_data <= '0;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_clr |=> (count == $past(count) || count == $past(count) + CW'(1))); // R1
  AST_HIST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!hist_en && !hist_clr) |=> $stable(count)); // R2
  AST_FILTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && filt_en && (|hit_v) && !hist_clr) |=> $stable(count)); // R4
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> (count == '0 && !full)); // R6
  AST_FLT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr |=> (flt_rdata == '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !hist_clr) |=> full); // R8
endmodule

// File: tb/cmd_hist_rec_tb_top.sv
module cmd_hist_rec_tb_top;
  logic clk = 0, rst_n = 0;
  logic hist_en = 0, filt_en = 0, cmd_valid = 0, hist_clr = 0, flt_clr = 0, flt_wr = 0;
  logic [7:0]  cmd_data = 0;
  logic [3:0]  flt_idx = 0;
  logic [16:0] flt_wdata = 0;
  logic [16:0] flt_rdata;
  logic [9:0]  count;
  logic        full;
  logic [8:0]  rd_idx = 0;
  logic [7:0]  rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmd_hist_rec dut_i (.*);

  // each entry: {command, 1 = expected to be kept}
  localparam logic [8:0] VEC [10] = '{
    {8'h01, 1'b1}, {8'h28, 1'b0}, {8'h29, 1'b1}, {8'h15, 1'b0}, {8'h1F, 1'b0},
    {8'h20, 1'b1}, {8'h55, 1'b1}, {8'h09, 1'b1}, {8'h10, 1'b0}, {8'h03, 1'b1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1; cmd_data = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wr_flt(input int i, input logic [16:0] v);
    @(negedge clk); flt_wr = 1; flt_idx = 4'(i); flt_wdata = v;
    @(negedge clk); flt_wr = 0;
  endtask

  task automatic rd_chk(input int i, input int exp, input string req);
    @(negedge clk); rd_idx = 9'(i);
    @(negedge clk); chk(rd_data == 8'(exp), req, rd_data, exp);
  endtask

  initial begin
    logic [7:0] model [10];
    int m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(count == 0 && !full, "R6 reset", count, 0);
    chk(rd_data == 0, "R9 reset", rd_data, 0);

    wr_flt(0, {1'b1, 8'h00, 8'h28});
    wr_flt(1, {1'b1, 8'h0F, 8'h10});
    wr_flt(2, {1'b0, 8'h00, 8'h55});
    flt_idx = 1;
    #1 chk(flt_rdata == {1'b1, 8'h0F, 8'h10}, "R3 readback", flt_rdata, {1'b1, 8'h0F, 8'h10});

    send(8'h44);
    chk(count == 0, "R2 capture off", count, 0);

    hist_en = 1; filt_en = 1;
    for (int v = 0; v < 10; v++) begin
      send(VEC[v][8:1]);
      if (VEC[v][0]) begin model[m] = VEC[v][8:1]; m++; end
      chk(count == 10'(m), VEC[v][0] ? "R1 keep" : "R4 drop", count, m);
    end
    for (int i = 0; i < m; i++) rd_chk(i, model[i], "R1 order");
    rd_chk(m, 0, "R9 beyond count");

    filt_en = 0;
    send(8'h28);
    chk(count == 10'(m + 1), "R5 filter off", count, m + 1);
    rd_chk(m, 8'h28, "R5 stored");

    @(negedge clk); flt_clr = 1; flt_wr = 1; flt_idx = 0; flt_wdata = 17'h1FFFF;
    @(negedge clk); flt_clr = 0; flt_wr = 0;
    #1 chk(flt_rdata == 0, "R7 clear wins", flt_rdata, 0);
    flt_idx = 1;
    #1 chk(flt_rdata == 0, "R7 entry1", flt_rdata, 0);
    filt_en = 1;
    send(8'h12);
    chk(count == 10'(m + 2), "R7 no match after clear", count, m + 2);

    @(negedge clk); hist_clr = 1;
    @(negedge clk); hist_clr = 0;
    filt_en = 0;
    @(negedge clk); cmd_valid = 1;
    for (int i = 0; i < 512; i++) begin
      cmd_data = 8'(i);
      @(negedge clk);
    end
    cmd_data = 8'hEE;
    repeat (3) @(negedge clk);
    cmd_valid = 0;
    chk(count == 512, "R8 saturate", count, 512);
    chk(full == 1, "R8 full", full, 1);
    rd_chk(511, 8'hFF, "R8 last entry");
    rd_chk(5, 8'h05, "R8 early entry");

    @(negedge clk); hist_clr = 1; cmd_valid = 1; cmd_data = 8'h77;
    @(negedge clk); hist_clr = 0; cmd_valid = 0;
    chk(count == 0, "R6 clear from full", count, 0);
    chk(full == 0, "R6 full drops", full, 0);

    @(negedge clk); hist_clr = 1; cmd_valid = 1; cmd_data = 8'h66;
    @(negedge clk); hist_clr = 0; cmd_valid = 0;
    chk(count == 0, "R6 command with clear", count, 0);
    rd_chk(0, 0, "R6 R9 empty read");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule